// File: doc/BRIEF.md
# Automatic RTS/CTS Hardware Flow Controller

This block sits beside a UART receive FIFO and transmitter and handles hardware handshaking with no help from software. On the receive side it drives the active-low RTS pin from the FIFO fill count. When the fill reaches a high-water mark, RTS is released to HIGH so that the far end stops sending. When the fill drops below a low-water mark, RTS is asserted LOW again. Between the two marks RTS keeps its previous level.

Automatic RTS control works only while the host keeps its own RTS request asserted. If automatic mode is off, the pin simply mirrors the host request as a general-purpose output. The block also raises a receive-trigger interrupt when the fill count reaches a programmed trigger level.

On the transmit side, the CTS pin passes through a two-flop synchronizer. When automatic CTS is on, a deasserted (HIGH) CTS withdraws the transmit permit. The serializer samples the permit only when it is about to start a character, so a character already in flight always finishes.

Top module: `flow_ctl`

## Requirements
- R1: While `rst_n` is low, on every clock edge `rts_n` becomes 1 and `rx_trig_irq` becomes 0, and every CTS synchronizer stage loads 1 (deasserted). Directly after reset, `tx_permit` is therefore 0 if `auto_cts_en` is 1.
- R2: With `auto_rts_en`=0, `rts_n` one cycle later equals the inverse of `host_rts_req` (1 = host asserts RTS, which drives the pin LOW).
- R3: With `host_rts_req`=0, `rts_n` is 1 one cycle later, whatever the fill count or mode.
- R4: With `auto_rts_en`=1 and `host_rts_req`=1, a fill count greater than or equal to `hi_lvl` drives `rts_n` to 1 one cycle later.
- R5: With `auto_rts_en`=1 and `host_rts_req`=1, a fill count strictly below `lo_lvl` drives `rts_n` to 0 one cycle later.
- R6: With automatic RTS active in consecutive cycles and `lo_lvl` <= count < `hi_lvl`, `rts_n` keeps its previous value.
- R7: `rx_trig_irq` one cycle later equals `auto_rts_en` AND (count >= `trig_lvl`).
- R8: With `auto_cts_en`=0, `tx_permit` is 1.
- R9: With `auto_cts_en`=1, `tx_permit` equals the inverse of `cts_n_pin` as it was two clock edges earlier.
- R10: Automatic RTS is not active while it is disabled or while the host request is withdrawn. During that time the halt condition is cleared, so on re-entry a count between the thresholds gives `rts_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_lvl | input | CNT_W | Receive interrupt trigger level |
| hi_lvl | input | CNT_W | High-water mark: RTS released at or above this level |
| lo_lvl | input | CNT_W | Low-water mark: RTS asserted below this level |
| auto_rts_en | input | 1 | Enable for automatic RTS |
| auto_cts_en | input | 1 | Enable for automatic CTS |
| host_rts_req | input | 1 | Host RTS request bit (1 = assert) |
| cts_n_pin | input | 1 | Raw active-low CTS pin |
| rts_n | output | 1 | Active-low RTS pin |
| rx_trig_irq | output | 1 | Receive trigger interrupt level |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
The bench builds the block with the default CNT_W of 6, so counts run from 0 to 63. The thresholds are set to 12, 16 and 20, which puts both hysteresis edges and the trigger well inside that range. It also sets low and high marks equal to each other, to show that the hold band can collapse, and it sets the high mark to 63, to show that the top of the count range still releases RTS. With a synchronizer depth of 2, both the one-cycle and the two-cycle latency of the CTS path can be observed at the pins.

// File: rtl/flowctl_pkg.sv
// Package flowctl_pkg
// Shared types for the flow controller. Assumes nothing beyond IEEE 1800-2017.
package flowctl_pkg;
    // Receive-side halt state of the RTS hysteresis engine
    typedef enum logic {
        FLOW_OPEN = 1'b0,
        FLOW_HALT = 1'b1
    } halt_e;

    // Depth of the CTS synchronizer chain
    localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/cts_sync.sv
// Module cts_sync
// Multi-flop synchronizer for the active-low CTS pin.
// Assumes the pin is asynchronous to clk. Every stage resets to 1 (deasserted).
module cts_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the chain of flops
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= pin_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rts_hyst.sv
// Module rts_hyst
// RTS hysteresis engine. It latches a halt state at or above the high mark
// and clears it below the low mark. The halt state is forced clear whenever
// automatic mode is inactive. Assumes lo_lvl <= hi_lvl.
module rts_hyst
    import flowctl_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] hi_lvl,
    input  logic [CNT_W-1:0] lo_lvl,
    input  logic             auto_en,
    input  logic             host_req,
    output logic             rts_n
);
    halt_e halt_q;
    halt_e halt_d;
    logic  active;
    logic  rts_n_q;

    assign active = auto_en && host_req;

    // Next halt state: set at the high mark, clear below the low mark, else hold
    always_comb begin
        if (!active)              halt_d = FLOW_OPEN;
        else if (count >= hi_lvl) halt_d = FLOW_HALT;
        else if (count <  lo_lvl) halt_d = FLOW_OPEN;
        else                      halt_d = halt_q;
    end

    // Register the halt state and the pin level together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q  <= FLOW_OPEN;
            rts_n_q <= 1'b1;
        end else begin
            halt_q  <= halt_d;
            rts_n_q <= !host_req || (halt_d == FLOW_HALT);
        end
    end

    assign rts_n = rts_n_q;
endmodule

// File: rtl/rx_trig_det.sv
// Module rx_trig_det
// Registered receive-trigger interrupt. It is high while automatic RTS is
// enabled and the fill count is at or above the trigger level.
module rx_trig_det #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             enable,
    output logic             irq
);
    logic irq_q;

    // Compare the fill count against the trigger and register the result
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= enable && (count >= trig_lvl);
    end

    assign irq = irq_q;
endmodule

// File: rtl/flow_ctl.sv
// Module flow_ctl
// Top level of the automatic RTS/CTS flow controller. The receive side drives
// RTS with hysteresis; the transmit side gates new characters on the
// synchronized CTS. Assumes the serializer samples tx_permit only at
// character start, so a character in flight always completes.
module flow_ctl
    import flowctl_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] hi_lvl,
    input  logic [CNT_W-1:0] lo_lvl,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             host_rts_req,
    input  logic             cts_n_pin,
    output logic             rts_n,
    output logic             rx_trig_irq,
    output logic             tx_permit
);
    logic cts_n_s;

    cts_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (cts_n_pin),
        .sync_n (cts_n_s)
    );

    rts_hyst #(.CNT_W(CNT_W)) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (rx_count),
        .hi_lvl   (hi_lvl),
        .lo_lvl   (lo_lvl),
        .auto_en  (auto_rts_en),
        .host_req (host_rts_req),
        .rts_n    (rts_n)
    );

    rx_trig_det #(.CNT_W(CNT_W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (rx_count),
        .trig_lvl (trig_lvl),
        .enable   (auto_rts_en),
        .irq      (rx_trig_irq)
    );

    // Permit a new character unless automatic CTS sees the far end deasserted
    assign tx_permit = !auto_cts_en || !cts_n_s;
endmodule

// File: rtl/flow_ctl_chk.sv
// Module flow_ctl_chk
// Property checker for flow_ctl. It observes only the ports and is attached
// to every flow_ctl instance by the bind below.
module flow_ctl_chk #(
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] trig_lvl,
    input logic [CNT_W-1:0] hi_lvl,
    input logic [CNT_W-1:0] lo_lvl,
    input logic             auto_rts_en,
    input logic             auto_cts_en,
    input logic             host_rts_req,
    input logic             cts_n_pin,
    input logic             rts_n,
    input logic             rx_trig_irq,
    input logic             tx_permit
);
    logic [1:0] since_rst;
    logic       act;

    assign act = auto_rts_en && host_rts_req;

    // Count the clock edges since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r2_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(host_rts_req)));

    a_r3_host_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rts_req |=> rts_n);

    a_r4_release_at_high: assert property (@(posedge clk) disable iff (!rst_n)
        (act && rx_count >= hi_lvl) |=> rts_n);

    a_r5_assert_below_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act && rx_count < lo_lvl) |=> !rts_n);

    a_r6_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && act && $past(act) && rx_count >= lo_lvl && rx_count < hi_lvl)
        |=> (rts_n == $past(rts_n)));

    a_r7_trig_irq: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rx_trig_irq == $past(auto_rts_en && (rx_count >= trig_lvl))));

    a_r8_cts_off_permit: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |-> tx_permit);

    a_r9_cts_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && auto_cts_en) |-> (tx_permit == !$past(cts_n_pin, 2)));
endmodule

bind flow_ctl flow_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_count     (rx_count),
    .trig_lvl     (trig_lvl),
    .hi_lvl       (hi_lvl),
    .lo_lvl       (lo_lvl),
    .auto_rts_en  (auto_rts_en),
    .auto_cts_en  (auto_cts_en),
    .host_rts_req (host_rts_req),
    .cts_n_pin    (cts_n_pin),
    .rts_n        (rts_n),
    .rx_trig_irq  (rx_trig_irq),
    .tx_permit    (tx_permit)
);

// File: tb/flow_ctl_test.sv
// Module flow_ctl_test
// Self-checking bench for flow_ctl: a vector table for the RTS and interrupt
// paths, followed by directed tests for CTS, thresholds and reset.
module flow_ctl_test;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] rx_count, trig_lvl, hi_lvl, lo_lvl;
    logic             auto_rts_en, auto_cts_en, host_rts_req, cts_n_pin;
    logic             rts_n, rx_trig_irq, tx_permit;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    flow_ctl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_lvl(trig_lvl),
        .hi_lvl(hi_lvl), .lo_lvl(lo_lvl), .auto_rts_en(auto_rts_en),
        .auto_cts_en(auto_cts_en), .host_rts_req(host_rts_req),
        .cts_n_pin(cts_n_pin), .rts_n(rts_n), .rx_trig_irq(rx_trig_irq),
        .tx_permit(tx_permit)
    );

    // 100 MHz clock
    always #5 clk = ~clk;

    // Vector fields: req[13:10] host[9] auto[8] count[7:2] exp_rts_n[1] exp_irq[0]
    // Thresholds: trig 16, high 20, low 12
    localparam logic [13:0] VEC [0:14] = '{
        {4'd2,  1'b1, 1'b0, 6'd0,  1'b0, 1'b0},  // R2 manual, asserted
        {4'd2,  1'b0, 1'b0, 6'd30, 1'b1, 1'b0},  // R2 manual, released; R7 gated
        {4'd5,  1'b1, 1'b1, 6'd5,  1'b0, 1'b0},  // R5 below the low mark
        {4'd6,  1'b1, 1'b1, 6'd16, 1'b0, 1'b1},  // R6 hold low; R7 at trigger
        {4'd6,  1'b1, 1'b1, 6'd19, 1'b0, 1'b1},  // R6 just under the high mark
        {4'd4,  1'b1, 1'b1, 6'd20, 1'b1, 1'b1},  // R4 at the high mark
        {4'd6,  1'b1, 1'b1, 6'd15, 1'b1, 1'b0},  // R6 hold high; R7 below trigger
        {4'd6,  1'b1, 1'b1, 6'd12, 1'b1, 1'b0},  // R6 exactly at the low mark
        {4'd5,  1'b1, 1'b1, 6'd11, 1'b0, 1'b0},  // R5 one below the low mark
        {4'd4,  1'b1, 1'b1, 6'd25, 1'b1, 1'b1},  // R4 above the high mark
        {4'd3,  1'b0, 1'b1, 6'd25, 1'b1, 1'b1},  // R3 host withdraws
        {4'd10, 1'b1, 1'b1, 6'd14, 1'b0, 1'b0},  // R10 re-entry clears halt
        {4'd4,  1'b1, 1'b1, 6'd22, 1'b1, 1'b1},  // R4 halt again
        {4'd2,  1'b1, 1'b0, 6'd22, 1'b0, 1'b0},  // R2 auto off overrides
        {4'd10, 1'b1, 1'b1, 6'd14, 1'b0, 1'b0}   // R10 re-enable clears halt
    };

    // Record one comparison
    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Apply count/host/mode, then sample after one edge
    task automatic step(input logic h, input logic a, input logic [CNT_W-1:0] c);
        host_rts_req = h;
        auto_rts_en  = a;
        rx_count     = c;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #1ms;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx_count = '0; trig_lvl = 6'd16; hi_lvl = 6'd20; lo_lvl = 6'd12;
        auto_rts_en = 1'b0; auto_cts_en = 1'b0; host_rts_req = 1'b0; cts_n_pin = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "rts_n in reset", rts_n, 1'b1);
        check("R1", "irq in reset", rx_trig_irq, 1'b0);
        check("R8", "permit with auto CTS off", tx_permit, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 15; i++) begin
            step(VEC[i][9], VEC[i][8], VEC[i][7:2]);
            check($sformatf("R%0d", VEC[i][13:10]), $sformatf("rts_n row %0d", i), rts_n, VEC[i][1]);
            check($sformatf("R%0d", VEC[i][13:10]), $sformatf("irq row %0d", i), rx_trig_irq, VEC[i][0]);
        end

        // R9: CTS latency of two edges
        auto_cts_en = 1'b1; cts_n_pin = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "permit with CTS high", tx_permit, 1'b0);
        cts_n_pin = 1'b0;
        @(negedge clk);
        check("R9", "permit after one edge", tx_permit, 1'b0);
        @(negedge clk);
        check("R9", "permit after two edges", tx_permit, 1'b1);
        cts_n_pin = 1'b1;
        @(negedge clk);
        check("R9", "permit still on after one edge", tx_permit, 1'b1);
        @(negedge clk);
        check("R9", "permit off after two edges", tx_permit, 1'b0);
        auto_cts_en = 1'b0;
        #1;
        check("R8", "permit when auto CTS cleared", tx_permit, 1'b1);
        @(negedge clk);

        // R4/R5: collapsed band, low mark equal to high mark
        hi_lvl = 6'd10; lo_lvl = 6'd10;
        step(1'b1, 1'b1, 6'd10);
        check("R4", "equal marks, at level", rts_n, 1'b1);
        step(1'b1, 1'b1, 6'd9);
        check("R5", "equal marks, below", rts_n, 1'b0);

        // R4: high mark at the top of the count range
        hi_lvl = 6'd63; lo_lvl = 6'd40;
        step(1'b1, 1'b1, 6'd62);
        check("R4", "one under max mark", rts_n, 1'b0);
        step(1'b1, 1'b1, 6'd63);
        check("R4", "max mark reached", rts_n, 1'b1);
        check("R7", "irq at max count", rx_trig_irq, 1'b1);

        // R1: reset in mid-run, with the pin low and CTS asserted
        step(1'b1, 1'b0, 6'd63);
        check("R2", "manual asserted before reset", rts_n, 1'b0);
        auto_cts_en = 1'b1; cts_n_pin = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", "permit before reset", tx_permit, 1'b1);
        auto_rts_en = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "rts_n after mid-run reset", rts_n, 1'b1);
        check("R1", "irq after mid-run reset", rx_trig_irq, 1'b0);
        check("R1", "sync reset withdraws permit", tx_permit, 1'b0);
        rst_n = 1'b1;
        auto_rts_en = 1'b0;
        @(negedge clk);
        check("R2", "manual after reset", rts_n, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule